// File: doc/BRIEF.md
# Round-robin averaging sequencer

This block walks a set of current-sense channels in a fixed rotating order and collects one 8-bit conversion result from an external converter on every visit. It tells the converter which channel to convert through a channel-select output; each time the converter presents a valid sample, the sample is credited to that channel and the select moves on to the next channel, wrapping after the last active one.

Every channel keeps a private running sum and visit count. Once a channel has collected the number of samples chosen by a 3-bit depth code (a power of two from 1 to 128), the sum is shifted right by the code and the 8-bit average is published to that channel's result byte in a single cycle. The result byte holds that value until the next average for the channel completes. Alongside the averaging path, every raw sample is passed on, tagged with its channel, to downstream overcurrent comparators. This raw path never waits for an average.

A parameter builds the block for four channels or for two. In the two-channel build the rotation covers only the first two channels, and the third and fourth result bytes are tied to zero.

Top module: `rr_avg_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, `smp_ch_o` is 0, every result byte of `avg_o` is 00h and `raw_valid_o` is 0.
- R2: Each cycle with `smp_valid_i` high advances `smp_ch_o` by one, from N_ACTIVE-1 back to 0. A cycle without a valid sample leaves `smp_ch_o` unchanged.
- R3: The depth is 2^code for codes 0 to 7 (000 gives 1 sample, 111 gives 128). On the clock edge that takes a channel's 2^code-th sample since its last publish or clear, the sum of those samples shifted right by code appears in that channel's byte of `avg_o` (byte c at bits 8c+7..8c). It is visible in the following cycle.
- R4: The running sum never overflows. At depth 128, a run of FFh samples publishes FFh.
- R5: Between two completions, a channel's result byte keeps the previously published value, even while partial sums are building.
- R6: Each channel averages only its own samples. Channels fed different values publish different averages at the same time.
- R7: On the cycle after each valid sample, `raw_valid_o` is 1, `raw_data_o` equals the sample and `raw_ch_o` equals the `smp_ch_o` value it was taken for. This holds whatever the depth, including on a depth-change cycle. With no valid sample, `raw_valid_o` is 0 on the next cycle.
- R8: On a cycle where `avg_sel_i` differs from the depth code in use, that cycle's sample is not summed, all partial sums and counts clear, and the new code takes effect. Published results keep their values.
- R9: The depth code in use resets to 100 (16 samples). If `avg_sel_i` stays at 100 through reset, no clear happens, and 16 visits per channel produce the first averages.
- R10: With N_ACTIVE = 2, `smp_ch_o` only takes the values 0 and 1, and result bytes 2 and 3 always read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| avg_sel_i | input | 3 | Averaging depth code, depth = 2^code |
| smp_valid_i | input | 1 | Converter presents a sample for the channel on `smp_ch_o` |
| smp_data_i | input | 8 | Unsigned conversion result |
| smp_ch_o | output | 2 | Channel the converter is asked to convert next |
| avg_o | output | 32 | Four 8-bit averaged results, channel c in bits 8c+7..8c |
| raw_valid_o | output | 1 | A raw sample was taken on the previous cycle |
| raw_data_o | output | 8 | That raw sample |
| raw_ch_o | output | 2 | Channel of that raw sample |

## Verification
The assertions assume the converter answers only for the channel currently on `smp_ch_o` and presents at most one sample per cycle. They also assume `avg_sel_i` is a synchronous, glitch-free level. The stimulus drives all inputs on the falling edge and credits each sample to the select value shown at that moment. The depth code changes only between directed phases or at sparse random points, so the clear-on-change path is exercised both with and without a sample on the change cycle. A two-channel instance runs on the same stimulus next to the four-channel one, so the shortened rotation and the zero-tied results are checked under identical traffic.

// File: rtl/avg_seq_pkg.sv
// Package avg_seq_pkg
// Shared constants and width helpers for the round-robin averaging sequencer.
// Assumes the depth code is a shift amount, so depth is always a power of two.
package avg_seq_pkg;
    localparam int unsigned SMP_W_DEF  = 8;
    localparam int unsigned CODE_W_DEF = 3;
    localparam int unsigned MAX_CH_DEF = 4;
    localparam logic [2:0]  RESET_CODE = 3'b100;

    // Largest shift a code of the given width can select.
    function automatic int unsigned max_shift(input int unsigned code_w);
        return (1 << code_w) - 1;
    endfunction

    // Sum width that holds the largest depth of full-scale samples.
    function automatic int unsigned acc_width(input int unsigned smp_w, input int unsigned code_w);
        return smp_w + max_shift(code_w);
    endfunction
endpackage

// File: rtl/avg_seq_depth_ctl.sv
// Module avg_seq_depth_ctl
// Holds the averaging depth code in use and flags the cycle on which the
// requested code differs from it. On that cycle every accumulator clears.
// Assumes avg_sel_i is a synchronous level.
module avg_seq_depth_ctl #(
    parameter int unsigned      CODE_W     = 3,
    parameter logic [CODE_W-1:0] RESET_CODE = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] avg_sel_i,
    output logic [CODE_W-1:0] code_o,
    output logic              chg_o
);
    logic [CODE_W-1:0] applied_q;

    // Track the requested code; the reset value sets the power-up depth.
    always_ff @(posedge clk) begin
        if (!rst_n) applied_q <= RESET_CODE;
        else        applied_q <= avg_sel_i;
    end

    // A mismatch between request and applied code marks a depth change.
    always_comb begin
        chg_o  = (avg_sel_i != applied_q);
        code_o = applied_q;
    end
endmodule

// File: rtl/avg_seq_rotator.sv
// Module avg_seq_rotator
// Channel pointer that steps once per accepted sample and wraps after the
// last active channel. Assumes N_ACTIVE is at least 1 and fits in CH_W bits.
module avg_seq_rotator #(
    parameter int unsigned N_ACTIVE = 4,
    parameter int unsigned CH_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    output logic [CH_W-1:0] ch_o
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_ACTIVE - 1);

    logic [CH_W-1:0] ptr_q;

    // Move to the next channel on each accepted sample, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ptr_q <= '0;
        else if (adv_i && ptr_q == LAST_CH) ptr_q <= '0;
        else if (adv_i)                     ptr_q <= ptr_q + 1'b1;
    end

    assign ch_o = ptr_q;

    // R2: with no accepted sample the pointer must not move.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(ptr_q));

    // R10: the pointer never names an inactive channel.
    assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) < int'(N_ACTIVE));
endmodule

// File: rtl/avg_seq_chan_acc.sv
// Module avg_seq_chan_acc
// Per-channel running sum and visit count. When the count reaches the depth,
// it publishes sum >> code in one cycle and restarts. Assumes take_i is only
// raised for samples that belong to this channel.
module avg_seq_chan_acc #(
    parameter int unsigned SMP_W  = 8,
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [SMP_W-1:0]  smp_i,
    output logic [SMP_W-1:0]  avg_o
);
    localparam int unsigned CNT_W   = avg_seq_pkg::max_shift(CODE_W);
    localparam int unsigned ACC_W   = avg_seq_pkg::acc_width(SMP_W, CODE_W);
    localparam int          MAX_SMP = (1 << SMP_W) - 1;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SMP_W-1:0] avg_q;
    logic [ACC_W-1:0] sum_next;
    logic [CNT_W:0]   depth_m1;
    logic             last;

    // Next sum, last-visit detect and the final count for the chosen depth.
    always_comb begin
        sum_next = acc_q + ACC_W'(smp_i);
        depth_m1 = ({{CNT_W{1'b0}}, 1'b1} << code_i) - 1'b1;
        last     = ({1'b0, cnt_q} == depth_m1);
    end

    // Sum, count and publish; a depth change drops partial sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            avg_q <= '0;
        end else if (clr_i) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take_i && last) begin
            acc_q <= '0;
            cnt_q <= '0;
            avg_q <= SMP_W'(sum_next >> code_i);
        end else if (take_i) begin
            acc_q <= sum_next;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign avg_o = avg_q;

    // R4: the sum is bounded by count times full scale, so it cannot wrap.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc_q) <= int'(cnt_q) * MAX_SMP);

    // R8: a depth change leaves no partial sum behind.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0 && acc_q == '0));

    // R5: the published value only moves right after a sample was taken.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(avg_q) |-> $past(take_i));
endmodule

// File: rtl/rr_avg_sequencer.sv
// Module rr_avg_sequencer
// Top of the round-robin averaging sequencer. It rotates the converter's
// channel select, gives every active channel its own accumulator, and
// forwards each raw sample with its channel tag one cycle later. Assumes the
// converter answers only for the channel shown on smp_ch_o.
module rr_avg_sequencer #(
    parameter int unsigned SMP_W    = avg_seq_pkg::SMP_W_DEF,
    parameter int unsigned CODE_W   = avg_seq_pkg::CODE_W_DEF,
    parameter int unsigned MAX_CH   = avg_seq_pkg::MAX_CH_DEF,
    parameter int unsigned N_ACTIVE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       avg_sel_i,
    input  logic                    smp_valid_i,
    input  logic [SMP_W-1:0]        smp_data_i,
    output logic [$clog2(MAX_CH)-1:0] smp_ch_o,
    output logic [MAX_CH*SMP_W-1:0] avg_o,
    output logic                    raw_valid_o,
    output logic [SMP_W-1:0]        raw_data_o,
    output logic [$clog2(MAX_CH)-1:0] raw_ch_o
);
    localparam int unsigned CH_W = $clog2(MAX_CH);

    logic [CODE_W-1:0] code;
    logic              chg;
    logic [CH_W-1:0]   cur_ch;
    logic              raw_valid_q;
    logic [SMP_W-1:0]  raw_data_q;
    logic [CH_W-1:0]   raw_ch_q;

    avg_seq_depth_ctl #(
        .CODE_W     (CODE_W),
        .RESET_CODE (CODE_W'(avg_seq_pkg::RESET_CODE))
    ) depth_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .avg_sel_i (avg_sel_i),
        .code_o    (code),
        .chg_o     (chg)
    );

    avg_seq_rotator #(
        .N_ACTIVE (N_ACTIVE),
        .CH_W     (CH_W)
    ) rot_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (smp_valid_i),
        .ch_o  (cur_ch)
    );

    // One accumulator per active channel; inactive result bytes read zero.
    for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
        if (g < N_ACTIVE) begin : g_act
            avg_seq_chan_acc #(
                .SMP_W  (SMP_W),
                .CODE_W (CODE_W)
            ) acc_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_i  (chg),
                .take_i (smp_valid_i && !chg && (cur_ch == CH_W'(g))),
                .code_i (code),
                .smp_i  (smp_data_i),
                .avg_o  (avg_o[g*SMP_W +: SMP_W])
            );
        end else begin : g_off
            assign avg_o[g*SMP_W +: SMP_W] = '0;
        end
    end

    // Pass every raw sample on with its channel tag, independent of averaging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_valid_q <= 1'b0;
            raw_data_q  <= '0;
            raw_ch_q    <= '0;
        end else begin
            raw_valid_q <= smp_valid_i;
            if (smp_valid_i) begin
                raw_data_q <= smp_data_i;
                raw_ch_q   <= cur_ch;
            end
        end
    end

    assign smp_ch_o    = cur_ch;
    assign raw_valid_o = raw_valid_q;
    assign raw_data_o  = raw_data_q;
    assign raw_ch_o    = raw_ch_q;

    // R7: each accepted sample appears on the raw port next cycle, tagged correctly.
    assert_raw_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> (raw_valid_o && raw_ch_o == $past(smp_ch_o)
                         && raw_data_o == $past(smp_data_i)));
endmodule

// File: tb/rr_avg_sequencer_tb_top.sv
`timescale 1ns/1ps
// Bench for rr_avg_sequencer: a four-channel and a two-channel instance share
// one stimulus. A behavioural model is compared with both on every cycle,
// and directed checks cover the hand-computed corner cases.
module rr_avg_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  avg_sel = 3'b100;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = 8'h00;

    logic [1:0]  ch_a, rch_a, ch_b, rch_b;
    logic [31:0] avg_a, avg_b;
    logic        rv_a, rv_b;
    logic [7:0]  rd_a, rd_b;

    int checks = 0;
    int failures = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    rr_avg_sequencer #(.N_ACTIVE(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .avg_sel_i(avg_sel), .smp_valid_i(smp_valid),
        .smp_data_i(smp_data), .smp_ch_o(ch_a), .avg_o(avg_a),
        .raw_valid_o(rv_a), .raw_data_o(rd_a), .raw_ch_o(rch_a));

    rr_avg_sequencer #(.N_ACTIVE(2)) dut2_i (
        .clk(clk), .rst_n(rst_n), .avg_sel_i(avg_sel), .smp_valid_i(smp_valid),
        .smp_data_i(smp_data), .smp_ch_o(ch_b), .avg_o(avg_b),
        .raw_valid_o(rv_b), .raw_data_o(rd_b), .raw_ch_o(rch_b));

    // Reference model state per instance (0: four channels, 1: two channels).
    int nch[2] = '{4, 2};
    int m_ptr[2];
    int m_acc[2][4];
    int m_cnt[2][4];
    int m_res[2][4];
    int m_app[2];
    int m_rv[2];
    int m_rd[2];
    int m_rc[2];

    // Model update: reads only bench-driven inputs, which are stable at the edge.
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_ptr[k] = 0; m_app[k] = 4; m_rv[k] = 0; m_rd[k] = 0; m_rc[k] = 0;
                for (int c = 0; c < 4; c++) begin
                    m_acc[k][c] = 0; m_cnt[k][c] = 0; m_res[k][c] = 0;
                end
            end else begin
                m_rv[k] = smp_valid;
                if (smp_valid) begin
                    m_rd[k] = smp_data;
                    m_rc[k] = m_ptr[k];
                end
                if (int'(avg_sel) != m_app[k]) begin
                    m_app[k] = avg_sel;
                    for (int c = 0; c < 4; c++) begin
                        m_acc[k][c] = 0; m_cnt[k][c] = 0;
                    end
                end else if (smp_valid) begin
                    m_acc[k][m_ptr[k]] += smp_data;
                    m_cnt[k][m_ptr[k]] += 1;
                    if (m_cnt[k][m_ptr[k]] == (1 << m_app[k])) begin
                        m_res[k][m_ptr[k]] = m_acc[k][m_ptr[k]] >> m_app[k];
                        m_acc[k][m_ptr[k]] = 0;
                        m_cnt[k][m_ptr[k]] = 0;
                    end
                end
                if (smp_valid) m_ptr[k] = (m_ptr[k] + 1) % nch[k];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare both instances with the model.
    task automatic compare_all();
        for (int k = 0; k < 2; k++) begin
            int a_ch, a_rv, a_rd, a_rc;
            logic [31:0] a_avg;
            logic [31:0] e_avg;
            a_ch  = (k == 0) ? int'(ch_a) : int'(ch_b);
            a_avg = (k == 0) ? avg_a : avg_b;
            a_rv  = (k == 0) ? int'(rv_a) : int'(rv_b);
            a_rd  = (k == 0) ? int'(rd_a) : int'(rd_b);
            a_rc  = (k == 0) ? int'(rch_a) : int'(rch_b);
            e_avg = '0;
            for (int c = 0; c < 4; c++)
                if (c < nch[k]) e_avg[8*c +: 8] = 8'(m_res[k][c]);
            chk("R2 channel select", a_ch, m_ptr[k]);
            chk("R3 averaged results", int'(a_avg), int'(e_avg));
            chk("R7 raw valid", a_rv, m_rv[k]);
            if (m_rv[k] != 0) begin
                chk("R7 raw data", a_rd, m_rd[k]);
                chk("R7 raw channel", a_rc, m_rc[k]);
            end
        end
    endtask

    // One cycle: check the previous edge's results, then drive new inputs.
    task automatic step(input bit v, input logic [7:0] d);
        @(negedge clk);
        if (model_on) compare_all();
        smp_valid = v;
        smp_data  = d;
    endtask

    task automatic idle();
        step(1'b0, 8'h00);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog (R1..R10 run) actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Reset phase, select held at the power-up depth code.
        repeat (3) @(negedge clk);
        chk("R1 select after reset", int'(ch_a), 0);
        chk("R1 results after reset", int'(avg_a), 0);
        chk("R1 raw valid after reset", int'(rv_a), 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        chk("R1 select first cycle", int'(ch_a), 0);
        chk("R1 results first cycle", int'(avg_a), 0);
        chk("R1 raw valid first cycle", int'(rv_a), 0);

        // R9 and R6: 16 visits per channel at the reset depth, per-channel values.
        for (int s = 0; s < 64; s++)
            step(1'b1, 8'(16 * ((s % 4) + 1) + 2 * ((s / 4) % 2)));
        idle();
        chk("R9 channel 0 after 16 visits", int'(avg_a[7:0]), 17);
        chk("R6 channel 1", int'(avg_a[15:8]), 33);
        chk("R6 channel 2", int'(avg_a[23:16]), 49);
        chk("R6 channel 3", int'(avg_a[31:24]), 65);
        chk("R10 upper bytes of two-channel build", int'(avg_b[31:16]), 0);

        // R5: depth 4, three visits each leave old results in place.
        avg_sel = 3'd2;
        idle();
        for (int s = 0; s < 12; s++) step(1'b1, 8'd100);
        idle();
        chk("R5 channel 0 holds old value", int'(avg_a[7:0]), 17);
        chk("R5 channel 3 holds old value", int'(avg_a[31:24]), 65);
        for (int s = 0; s < 4; s++) step(1'b1, 8'd100);
        idle();
        chk("R3 depth 4 result", int'(avg_a), 32'h64646464);

        // R8: partial sums of 200 are dropped by a depth change.
        for (int s = 0; s < 8; s++) step(1'b1, 8'd200);
        avg_sel = 3'd1;
        idle();
        idle();
        chk("R8 results kept across change", int'(avg_a), 32'h64646464);
        for (int s = 0; s < 8; s++) step(1'b1, 8'd50);
        idle();
        chk("R8 no mixing after change", int'(avg_a), 32'h32323232);

        // R4: 128 full-scale samples per channel.
        avg_sel = 3'd7;
        idle();
        for (int s = 0; s < 512; s++) step(1'b1, 8'hFF);
        idle();
        chk("R4 full scale at depth 128", int'(avg_a), 32'hFFFFFFFF);

        // Random traffic with gaps and sparse depth changes, model-compared.
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 60) == 0) avg_sel = 3'($urandom % 4);
            step(($urandom % 3) != 0, 8'($urandom));
        end
        idle();
        chk("R10 upper bytes stay zero", int'(avg_b[31:16]), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule